// File: doc/BRIEF.md
# Strip Hit Detection Input Stage

This block is the first digital stage behind the discriminators of a binary strip readout chip. On every beam-crossing clock edge it captures one discriminator bit per channel and keeps the last three captured bits of each channel as a short time window. A programmable criterion turns each channel's window into a single hit bit. The result is a registered hit vector for the trigger pipeline, one vector per crossing.

One register bank serves two purposes. A per-channel bit can either suppress that channel's hit output (mask use) or force a 1 into that channel's sample path in place of the discriminator (test-pulse use). A single select input decides which of the two uses applies. The bank and the 2-bit criterion register are written through a simple word-wide write port. The channel count is a parameter with a default of 256.

Top module: `strip_hit_frontend`

## Requirements
- R1: While `rst_n` is low at a clock edge, every history sample, every bank bit and `hit_out` are cleared, and the criterion register returns to 01 (level).
- R2: Each edge shifts every channel's window: the newest sample moves to the middle, the middle moves to the oldest, and the channel's current input is captured as the newest. `hit_out` is registered, so it reflects the window as it stood before the same edge that captures the next sample.
- R3: With criterion 00 (any), a channel is flagged when at least one of its three samples is 1.
- R4: With criterion 01 (level), a channel is flagged exactly when its middle sample is 1, regardless of the oldest and newest samples.
- R5: With criterion 10 (edge), a channel is flagged when its oldest sample is 0 and its middle sample is 1; the newest sample has no effect.
- R6: With criterion 11 (clear), no channel is flagged, whatever the inputs.
- R7: When `test_sel` is 0, a set bank bit forces that channel's `hit_out` bit to 0 and the discriminator input is sampled unchanged.
- R8: When `test_sel` is 1, a set bank bit makes that channel sample a 1 instead of its discriminator bit; clear bank bits sample the discriminator, and no channel is masked.
- R9: A write with `wr_en` high loads `wr_data` into bank bits `wr_addr*WORD_W` up to `wr_addr*WORD_W+WORD_W-1` (bit 0 of the data to the lowest channel) and leaves the other words unchanged.
- R10: A write with `mode_wr_en` high loads `mode_wr_data` into the criterion register at that edge; the new criterion governs the hit vector produced at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disc_in | input | NUM_CH | Discriminator output, one bit per channel |
| test_sel | input | 1 | 0: bank acts as mask, 1: bank acts as test-pulse pattern |
| wr_en | input | 1 | Write strobe for one bank word |
| wr_addr | input | ADDR_W | Bank word index |
| wr_data | input | WORD_W | Bank word contents |
| mode_wr_en | input | 1 | Write strobe for the criterion register |
| mode_wr_data | input | 2 | Criterion: 00 any, 01 level, 10 edge, 11 clear |
| hit_out | output | NUM_CH | Registered hit vector |

## Verification
A single pulse on one channel under the reset criterion pins down the window delay and shows that level responds to the middle sample only. Sparse random discriminator traffic is run under each criterion, where isolated pulses, back-to-back pairs and gaps separate any, level and edge from one another and from a mis-ordered window. Dense all-ones traffic under the clear criterion and with a random mask shows that nothing leaks through, while a quiet discriminator with the bank in test use shows the injected pattern, including one written word, emerging alone. A phase that rewrites the criterion on many edges exposes any off-by-one in when a new criterion takes effect.

// File: rtl/strip_fe_pkg.sv
// Package: strip_fe_pkg
// Shared types of the strip hit detection input stage.
// Assumes: the criterion code is two bits wide and its values are fixed
// by the chip's configuration format.
package strip_fe_pkg;

    // Hit selection criteria over a three-sample window.
    typedef enum logic [1:0] {
        CRIT_ANY   = 2'b00,
        CRIT_LEVEL = 2'b01,
        CRIT_EDGE  = 2'b10,
        CRIT_OFF   = 2'b11
    } crit_e;

    // Criterion loaded by reset.
    localparam crit_e CRIT_RESET = CRIT_LEVEL;

    // Decide one channel's hit from its window (oldest, middle, newest).
    function automatic logic crit_eval(input crit_e crit,
                                       input logic  s_old,
                                       input logic  s_mid,
                                       input logic  s_new);
        logic r;
        case (crit)
            CRIT_ANY:   r = s_old | s_mid | s_new;
            CRIT_LEVEL: r = s_mid;
            CRIT_EDGE:  r = ~s_old & s_mid;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/strip_cfg_regs.sv
// Module: strip_cfg_regs
// Holds the shared mask / test-pattern bank and the criterion register.
// The bank is split into NUM_CH/WORD_W words, each written as a whole.
// Assumes: NUM_CH is a multiple of WORD_W and NUM_CH/WORD_W >= 2.
module strip_cfg_regs
    import strip_fe_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int WORD_W = 32,
    localparam int NUM_WORDS = NUM_CH / WORD_W,
    localparam int ADDR_W = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              mode_wr_en,
    input  logic [1:0]        mode_wr_data,
    output logic [NUM_CH-1:0] bank_q,
    output crit_e             crit_q
);

    // One register word per bank slice, each with its own address decode.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit_word;
        assign hit_word = wr_en && (wr_addr == ADDR_W'(w));

        // Load this word when the write address selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[w*WORD_W +: WORD_W] <= '0;
            end else if (hit_word) begin
                bank_q[w*WORD_W +: WORD_W] <= wr_data;
            end
        end
    end

    // Criterion register: reset to level, loaded by the mode strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_q <= CRIT_RESET;
        end else if (mode_wr_en) begin
            crit_q <= crit_e'(mode_wr_data);
        end
    end

endmodule

// File: rtl/strip_sample_hist.sv
// Module: strip_sample_hist
// Captures the discriminator bits each crossing and keeps a three-deep
// history per channel. In test use, a set bank bit replaces the
// discriminator bit with a 1 before capture.
// Assumes: disc_in is already synchronous to clk.
module strip_sample_hist #(
    parameter int NUM_CH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] disc_in,
    input  logic [NUM_CH-1:0] bank_q,
    input  logic              test_sel,
    output logic [NUM_CH-1:0] hist_old,
    output logic [NUM_CH-1:0] hist_mid,
    output logic [NUM_CH-1:0] hist_new
);

    logic [NUM_CH-1:0] sample_d;

    // Per channel: inject a 1 where the bank asks for it in test use.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_inj
        assign sample_d[c] = disc_in[c] | (test_sel & bank_q[c]);
    end

    // Shift the three-sample window by one crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_old <= '0;
            hist_mid <= '0;
            hist_new <= '0;
        end else begin
            hist_old <= hist_mid;
            hist_mid <= hist_new;
            hist_new <= sample_d;
        end
    end

endmodule

// File: rtl/strip_hit_select.sv
// Module: strip_hit_select
// Applies the selected criterion to every channel's window, gates the
// result with the mask when the bank is in mask use, and registers the
// hit vector.
// Assumes: crit_q and bank_q are stable register outputs.
module strip_hit_select
    import strip_fe_pkg::*;
#(
    parameter int NUM_CH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  crit_e             crit_q,
    input  logic [NUM_CH-1:0] hist_old,
    input  logic [NUM_CH-1:0] hist_mid,
    input  logic [NUM_CH-1:0] hist_new,
    input  logic [NUM_CH-1:0] bank_q,
    input  logic              test_sel,
    output logic [NUM_CH-1:0] hit_out
);

    logic [NUM_CH-1:0] hit_d;

    // Per channel: criterion decision, then mask gate in mask use.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic raw_hit;
        assign raw_hit  = crit_eval(crit_q, hist_old[c], hist_mid[c], hist_new[c]);
        assign hit_d[c] = raw_hit & ~(bank_q[c] & ~test_sel);
    end

    // Register the hit vector once per crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_out <= '0;
        end else begin
            hit_out <= hit_d;
        end
    end

endmodule

// File: rtl/strip_hit_frontend.sv
// Module: strip_hit_frontend
// Top of the strip hit detection input stage: configuration bank,
// sample history and hit selection.
// Assumes: one clock domain (beam-crossing clock), synchronous reset.
module strip_hit_frontend
    import strip_fe_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int WORD_W = 32,
    localparam int NUM_WORDS = NUM_CH / WORD_W,
    localparam int ADDR_W = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] disc_in,
    input  logic              test_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              mode_wr_en,
    input  logic [1:0]        mode_wr_data,
    output logic [NUM_CH-1:0] hit_out
);

    logic [NUM_CH-1:0] bank_q;
    crit_e             crit_q;
    logic [NUM_CH-1:0] hist_old;
    logic [NUM_CH-1:0] hist_mid;
    logic [NUM_CH-1:0] hist_new;

    strip_cfg_regs #(
        .NUM_CH (NUM_CH),
        .WORD_W (WORD_W)
    ) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .bank_q       (bank_q),
        .crit_q       (crit_q)
    );

    strip_sample_hist #(
        .NUM_CH (NUM_CH)
    ) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .disc_in  (disc_in),
        .bank_q   (bank_q),
        .test_sel (test_sel),
        .hist_old (hist_old),
        .hist_mid (hist_mid),
        .hist_new (hist_new)
    );

    strip_hit_select #(
        .NUM_CH (NUM_CH)
    ) sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .crit_q   (crit_q),
        .hist_old (hist_old),
        .hist_mid (hist_mid),
        .hist_new (hist_new),
        .bank_q   (bank_q),
        .test_sel (test_sel),
        .hit_out  (hit_out)
    );

endmodule

// File: rtl/strip_fe_checker.sv
// Module: strip_fe_checker
// Property checks for strip_hit_frontend, attached by bind below.
// Assumes: it sees the top's ports plus the bank, criterion and history.
module strip_fe_checker
    import strip_fe_pkg::*;
#(
    parameter int NUM_CH = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_sel,
    input logic [NUM_CH-1:0] hit_out,
    input logic [NUM_CH-1:0] bank_q,
    input crit_e             crit_q,
    input logic [NUM_CH-1:0] hist_old,
    input logic [NUM_CH-1:0] hist_mid,
    input logic [NUM_CH-1:0] hist_new
);

    // R1: reset clears outputs and history and restores the level criterion.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (hit_out == '0 && hist_old == '0 && hist_mid == '0 &&
                    hist_new == '0 && bank_q == '0 && crit_q == CRIT_LEVEL));

    // R2: the window moves by one position per crossing.
    assert_window_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (hist_old == $past(hist_mid) && hist_mid == $past(hist_new)));

    // R3: an all-zero window never produces a hit under the any criterion.
    assert_any_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_q == CRIT_ANY && (hist_old | hist_mid | hist_new) == '0)
        |=> hit_out == '0);

    // R4: level ignores everything but the middle sample.
    assert_level_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_q == CRIT_LEVEL && hist_mid == '0) |=> hit_out == '0);

    // R5: with every oldest sample high, the edge criterion flags nothing.
    assert_edge_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_q == CRIT_EDGE && hist_old == '1) |=> hit_out == '0);

    // R6: the clear criterion flags nothing.
    assert_clear_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_q == CRIT_OFF) |=> hit_out == '0);

    // R7: masked channels stay silent in mask use.
    assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_sel |=> ((hit_out & $past(bank_q)) == '0));

    // R8: in test use every set bank bit is captured as a 1.
    assert_inject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_sel |=> ((hist_new & $past(bank_q)) == $past(bank_q)));

endmodule

bind strip_hit_frontend strip_fe_checker #(
    .NUM_CH (NUM_CH)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_sel (test_sel),
    .hit_out  (hit_out),
    .bank_q   (bank_q),
    .crit_q   (crit_q),
    .hist_old (hist_old),
    .hist_mid (hist_mid),
    .hist_new (hist_new)
);

// File: tb/strip_hit_frontend_tb.sv
// Bench for strip_hit_frontend: directed corners plus seeded random
// traffic, compared each crossing against a requirement-level model.
module strip_hit_frontend_tb_top;

    localparam int NUM_CH    = 256;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = NUM_CH / WORD_W;
    localparam int ADDR_W    = $clog2(NUM_WORDS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] disc_in = '0;
    logic              test_sel = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              mode_wr_en = 1'b0;
    logic [1:0]        mode_wr_data = 2'b00;
    logic [NUM_CH-1:0] hit_out;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    // Bench model state.
    logic [NUM_CH-1:0] m_old = '0, m_mid = '0, m_new = '0, m_bank = '0;
    logic [1:0]        m_mode = 2'b01;
    logic [NUM_CH-1:0] exp_hit = '0;

    always #2.5 clk = ~clk;

    strip_hit_frontend #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .test_sel(test_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .hit_out(hit_out)
    );

    // Criterion per requirement R3..R6 (oldest, middle, newest).
    function automatic logic [NUM_CH-1:0] want(input logic [1:0] md,
            input logic [NUM_CH-1:0] o, input logic [NUM_CH-1:0] m,
            input logic [NUM_CH-1:0] n);
        case (md)
            2'b00:   return o | m | n;
            2'b01:   return m;
            2'b10:   return ~o & m;
            default: return '0;
        endcase
    endfunction

    // Model of one clock edge using the inputs currently driven.
    task automatic model_edge();
        logic [NUM_CH-1:0] smp;
        if (!rst_n) begin
            m_old = '0; m_mid = '0; m_new = '0; m_bank = '0;
            m_mode = 2'b01; exp_hit = '0;
        end else begin
            smp = test_sel ? (disc_in | m_bank) : disc_in;
            exp_hit = want(m_mode, m_old, m_mid, m_new) &
                      ~(test_sel ? '0 : m_bank);
            m_old = m_mid; m_mid = m_new; m_new = smp;
            if (wr_en) m_bank[wr_addr*WORD_W +: WORD_W] = wr_data;
            if (mode_wr_en) m_mode = mode_wr_data;
        end
    endtask

    task automatic check(input string tag);
        n_total++;
        if (hit_out !== exp_hit) begin
            n_bad++;
            $display("FAIL %s: hit_out=%h expected=%h", tag, hit_out, exp_hit);
        end
    endtask

    // One crossing: model, edge, then compare in the low phase.
    task automatic step(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        mode_wr_en = 1'b0;
        check(tag);
    endtask

    function automatic logic [NUM_CH-1:0] rand_vec(input int density);
        logic [NUM_CH-1:0] v;
        for (int w = 0; w < NUM_WORDS; w++) begin
            logic [WORD_W-1:0] x;
            x = $urandom();
            for (int k = 1; k < density; k++) x = x & $urandom();
            v[w*WORD_W +: WORD_W] = x;
        end
        return v;
    endfunction

    task automatic set_mode(input logic [1:0] md, input string tag);
        mode_wr_en = 1'b1;
        mode_wr_data = md;
        step(tag);
    endtask

    task automatic run_random(input int cycles, input int density,
                              input string tag);
        for (int i = 0; i < cycles; i++) begin
            disc_in = rand_vec(density);
            step(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        repeat (3) begin model_edge(); @(posedge clk); @(negedge clk); end
        check("R1 reset output");
        rst_n = 1'b1;

        // R1/R2/R4: single pulse on channel 5 under the reset criterion.
        disc_in = '0; disc_in[5] = 1'b1;
        step("R2 pulse capture");
        disc_in = '0;
        for (int i = 0; i < 4; i++) step("R1 R2 R4 default level pulse");

        // R3: any criterion with sparse traffic.
        set_mode(2'b00, "R10 to any");
        run_random(40, 3, "R3 any");
        // R4: level criterion.
        set_mode(2'b01, "R10 to level");
        run_random(40, 2, "R4 level");
        // R5: edge criterion.
        set_mode(2'b10, "R10 to edge");
        run_random(40, 2, "R5 edge");
        // R6: clear criterion with dense and all-ones traffic.
        set_mode(2'b11, "R10 to clear");
        disc_in = '1;
        for (int i = 0; i < 5; i++) step("R6 clear all ones");
        run_random(20, 1, "R6 clear random");

        // R7: random mask, mask use, any criterion, dense traffic.
        set_mode(2'b00, "R10 to any");
        for (int w = 0; w < NUM_WORDS; w++) begin
            wr_en = 1'b1; wr_addr = ADDR_W'(w); wr_data = $urandom();
            disc_in = rand_vec(1);
            step("R7 mask load");
        end
        disc_in = '1;
        for (int i = 0; i < 5; i++) step("R7 mask all ones");
        run_random(30, 1, "R7 mask random");

        // R8: test use with a quiet discriminator, level criterion.
        set_mode(2'b01, "R10 to level");
        disc_in = '0;
        test_sel = 1'b1;
        for (int i = 0; i < 5; i++) step("R8 inject");
        run_random(20, 3, "R8 inject plus disc");

        // R9: clear bank, set word 3 to all ones; only channels 96..127 fire.
        for (int w = 0; w < NUM_WORDS; w++) begin
            wr_en = 1'b1; wr_addr = ADDR_W'(w); wr_data = '0;
            disc_in = '0;
            step("R9 bank clear");
        end
        wr_en = 1'b1; wr_addr = ADDR_W'(3); wr_data = '1;
        step("R9 word write");
        for (int i = 0; i < 5; i++) step("R9 word three only");
        wr_en = 1'b1; wr_addr = ADDR_W'(6); wr_data = 32'hA5A5_0F0F;
        step("R9 second word");
        for (int i = 0; i < 4; i++) step("R9 two words");

        // R10: criterion rewritten on many edges under random traffic.
        test_sel = 1'b0;
        for (int i = 0; i < 60; i++) begin
            disc_in = rand_vec(2);
            if ($urandom_range(0, 1) == 1) begin
                mode_wr_en = 1'b1;
                mode_wr_data = 2'($urandom_range(0, 3));
            end
            test_sel = ($urandom_range(0, 3) == 0);
            step("R10 mode churn");
        end

        // R1: reset in the middle of traffic, then level pulse again.
        rst_n = 1'b0;
        disc_in = '1;
        step("R1 mid reset");
        step("R1 mid reset held");
        rst_n = 1'b1;
        disc_in = '0; disc_in[200] = 1'b1;
        step("R1 after reset");
        disc_in = '0;
        for (int i = 0; i < 3; i++) step("R1 R4 level after reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule